// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a 32-bit physical address by reading two table entries from memory. A single directory of 4096 word entries sits at an address held in a base register. Each valid directory entry points at a 256-entry page table. Each valid page entry gives a 4 KiB page frame and a 4-bit authority index. The authority index is passed on to a downstream permission stage and is not interpreted here.

A client presents a virtual address with a one-cycle request strobe. The walker then issues one word read per level on a simple request/response memory port. It reports the physical address, the authority index and a fault indication together on a one-cycle result strobe. It accepts one translation at a time.

When a walk finds an invalid entry, the faulting virtual address is recorded in a separate address register for each level. A sticky status bit is raised for that level, and software clears it by writing one to it.

Top module: `xlat_walker`

## Requirements
- R1: After reset, busy, mem_req and rsp_valid are 0, flt_status is all zeros, and both error address registers read 0.
- R2: The first memory read of a walk is at base + iova[31:20]*4. The base is the last value written with base_we.
- R3: A directory entry is valid only when entry[1:0] == 2'b01. When it is valid, the second read is at (entry & 32'hFFFF_FC00) + iova[19:12]*4, so entry bits 9:2 are ignored.
- R4: A page entry is valid when entry bit 1 is 1. On a valid page entry the result is rsp_pa = {entry[31:12], iova[11:0]} and rsp_aci = entry[7:4], with rsp_fault = 0. Page entry bits 11:8, bits 3:2 and bit 0 have no effect.
- R5: An invalid directory entry ends the walk after one read. It returns rsp_fault=1, rsp_fault_lvl2=0, rsp_pa=0 and rsp_aci=0. It sets flt_status bit 16 and loads l1_err_addr with the iova.
- R6: An invalid page entry returns rsp_fault=1, rsp_fault_lvl2=1, rsp_pa=0 and rsp_aci=0. It sets flt_status bit 17 and loads l2_err_addr with the iova.
- R7: A request is accepted only while busy is 0. busy rises in the cycle after acceptance and stays high through the result cycle. req_valid is ignored while busy is 1.
- R8: rsp_valid is high for exactly one cycle per accepted request.
- R9: The flt_status bits are sticky. Writing with flt_clr_we=1 clears each status bit whose flt_clr_data bit is 1 (flt_clr_data[16] clears bit 16, flt_clr_data[17] clears bit 17). A new fault in the same cycle wins over the clear. The error address registers are not affected by the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Load the directory base register |
| base_wdata | input | 32 | New directory base address |
| req_valid | input | 1 | Translation request strobe |
| req_iova | input | 32 | Virtual address to translate |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Result strobe, one cycle |
| rsp_pa | output | 32 | Physical address (0 on fault) |
| rsp_aci | output | 4 | Authority index from the page entry (0 on fault) |
| rsp_fault | output | 1 | The walk hit an invalid entry |
| rsp_fault_lvl2 | output | 1 | The fault was at the page table level |
| flt_clr_we | input | 1 | Write-one-to-clear strobe for the status bits |
| flt_clr_data | input | 2 | Clear mask for status bits 17:16 |
| flt_status | output | 32 | Sticky fault flags at bits 16 (directory) and 17 (page) |
| l1_err_addr | output | 32 | Last virtual address that faulted at the directory |
| l2_err_addr | output | 32 | Last virtual address that faulted at the page table |

## Verification
A wrong walk state first shows on mem_addr. A mis-split index or an unmasked table base gives a wrong address in the very cycle the read is issued, before any result is returned. A wrong validity decode shows as a second read that should not happen, or a missing one, and then as wrong rsp_fault and rsp_pa values one cycle after the read data arrives. Fault-flag damage lasts: a status bit that was set or cleared wrongly stays visible on flt_status until the next clear write.

// File: rtl/xw_pkg.sv
package xw_pkg;

    localparam int unsigned VA_W       = 32;
    localparam int unsigned DIR_IDX_W  = 12;
    localparam int unsigned PT_IDX_W   = 8;
    localparam int unsigned OFS_W      = VA_W - DIR_IDX_W - PT_IDX_W;
    localparam int unsigned ACI_W      = 4;
    localparam int unsigned ENT_SHIFT  = 2;
    localparam int unsigned FRAME_W    = VA_W - OFS_W;
    localparam int unsigned PTB_LOW    = PT_IDX_W + ENT_SHIFT;
    localparam int unsigned ACI_LSB    = 4;
    localparam int unsigned PTE_VLD    = 1;
    localparam int unsigned ST_L1_BIT  = 16;
    localparam int unsigned ST_L2_BIT  = 17;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIR_REQ,
        S_DIR_WAIT,
        S_PTE_REQ,
        S_PTE_WAIT,
        S_DONE
    } walk_state_e;

    typedef struct packed {
        logic [DIR_IDX_W-1:0] dir;
        logic [PT_IDX_W-1:0]  pt;
        logic [OFS_W-1:0]     ofs;
    } va_split_t;

    typedef struct packed {
        logic            valid;
        logic [VA_W-1:0] pt_base;
    } dir_dec_t;

    typedef struct packed {
        logic               valid;
        logic [FRAME_W-1:0] frame;
        logic [ACI_W-1:0]   aci;
    } pte_dec_t;

    typedef struct packed {
        logic [VA_W-1:0]  pa;
        logic [ACI_W-1:0] aci;
        logic             fault;
        logic             lvl2;
    } walk_rsp_t;

    function automatic dir_dec_t decode_dir(input logic [VA_W-1:0] ent);
        dir_dec_t d;
        d.valid   = (ent[1:0] == 2'b01);
        d.pt_base = {ent[VA_W-1:PTB_LOW], {PTB_LOW{1'b0}}};
        return d;
    endfunction

    function automatic pte_dec_t decode_pte(input logic [VA_W-1:0] ent);
        pte_dec_t p;
        p.valid = ent[PTE_VLD];
        p.frame = ent[VA_W-1:OFS_W];
        p.aci   = ent[ACI_LSB +: ACI_W];
        return p;
    endfunction

    function automatic logic [VA_W-1:0] entry_addr(input logic [VA_W-1:0] base,
                                                   input logic [VA_W-1:0] idx);
        return base + (idx << ENT_SHIFT);
    endfunction

endpackage

// File: rtl/xw_walk_ctrl.sv
module xw_walk_ctrl
    import xw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [VA_W-1:0]  dir_base,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_iova,
    output logic             busy,
    output logic             mem_req,
    output logic [VA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [VA_W-1:0]  mem_rdata,
    output logic             rsp_valid,
    output walk_rsp_t        rsp,
    output logic             set_l1,
    output logic             set_l2,
    output logic [VA_W-1:0]  cur_iova
);

    walk_state_e     state;
    va_split_t       va_q;
    logic [VA_W-1:0] ptb_q;
    walk_rsp_t       rsp_q;
    dir_dec_t        dd;
    pte_dec_t        pd;

    assign dd = decode_dir(mem_rdata);
    assign pd = decode_pte(mem_rdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            va_q  <= '0;
            ptb_q <= '0;
            rsp_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        va_q  <= va_split_t'(req_iova);
                        state <= S_DIR_REQ;
                    end
                end
                S_DIR_REQ: state <= S_DIR_WAIT;
                S_DIR_WAIT: begin
                    if (mem_rvalid) begin
                        if (dd.valid) begin
                            ptb_q <= dd.pt_base;
                            state <= S_PTE_REQ;
                        end else begin
                            rsp_q <= '{pa: '0, aci: '0, fault: 1'b1, lvl2: 1'b0};
                            state <= S_DONE;
                        end
                    end
                end
                S_PTE_REQ: state <= S_PTE_WAIT;
                S_PTE_WAIT: begin
                    if (mem_rvalid) begin
                        if (pd.valid)
                            rsp_q <= '{pa: {pd.frame, va_q.ofs}, aci: pd.aci,
                                       fault: 1'b0, lvl2: 1'b0};
                        else
                            rsp_q <= '{pa: '0, aci: '0, fault: 1'b1, lvl2: 1'b1};
                        state <= S_DONE;
                    end
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req  = 1'b0;
        mem_addr = '0;
        if (state == S_DIR_REQ) begin
            mem_req  = 1'b1;
            mem_addr = entry_addr(dir_base, VA_W'(va_q.dir));
        end else if (state == S_PTE_REQ) begin
            mem_req  = 1'b1;
            mem_addr = entry_addr(ptb_q, VA_W'(va_q.pt));
        end
    end

    assign busy      = (state != S_IDLE);
    assign rsp_valid = (state == S_DONE);
    assign rsp       = rsp_q;
    assign set_l1    = (state == S_DIR_WAIT) && mem_rvalid && !dd.valid;
    assign set_l2    = (state == S_PTE_WAIT) && mem_rvalid && !pd.valid;
    assign cur_iova  = va_q;

    // R8: result strobe lasts one cycle
    p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R7: an idle request makes the walker busy on the next cycle
    p_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid) |=> busy);

    // R7: a memory read only happens inside a walk
    p_req_in_walk_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R5: a faulted result carries no address or index
    p_fault_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp.fault) |-> (rsp.pa == '0 && rsp.aci == '0));

    // R6: a level-2 flag never comes without the fault flag
    p_lvl2_has_fault_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp.lvl2) |-> rsp.fault);

endmodule

// File: rtl/xw_fault_log.sv
module xw_fault_log
    import xw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            set_l1,
    input  logic            set_l2,
    input  logic [VA_W-1:0] iova,
    input  logic            clr_l1,
    input  logic            clr_l2,
    output logic            st_l1,
    output logic            st_l2,
    output logic [VA_W-1:0] l1_addr,
    output logic [VA_W-1:0] l2_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_l1   <= 1'b0;
            st_l2   <= 1'b0;
            l1_addr <= '0;
            l2_addr <= '0;
        end else begin
            st_l1 <= set_l1 | (st_l1 & ~clr_l1);
            st_l2 <= set_l2 | (st_l2 & ~clr_l2);
            if (set_l1) l1_addr <= iova;
            if (set_l2) l2_addr <= iova;
        end
    end

    // R9: status bit holds without a matching clear
    p_l1_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (st_l1 && !clr_l1) |=> st_l1);

    p_l2_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (st_l2 && !clr_l2) |=> st_l2);

    // R5: a directory fault is captured with its address
    p_l1_capture_r5: assert property (@(posedge clk) disable iff (rst)
        set_l1 |=> (st_l1 && l1_addr == $past(iova)));

    // R6: a page fault is captured with its address
    p_l2_capture_r6: assert property (@(posedge clk) disable iff (rst)
        set_l2 |=> (st_l2 && l2_addr == $past(iova)));

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xw_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       base_we,
    input  logic [31:0]                base_wdata,
    input  logic                       req_valid,
    input  logic [31:0]                req_iova,
    output logic                       busy,
    output logic                       mem_req,
    output logic [31:0]                mem_addr,
    input  logic                       mem_rvalid,
    input  logic [31:0]                mem_rdata,
    output logic                       rsp_valid,
    output logic [31:0]                rsp_pa,
    output logic [3:0]                 rsp_aci,
    output logic                       rsp_fault,
    output logic                       rsp_fault_lvl2,
    input  logic                       flt_clr_we,
    input  logic [ST_L2_BIT:ST_L1_BIT] flt_clr_data,
    output logic [31:0]                flt_status,
    output logic [31:0]                l1_err_addr,
    output logic [31:0]                l2_err_addr
);

    logic [VA_W-1:0] base_q;
    walk_rsp_t       rsp_w;
    logic            set_l1_w, set_l2_w;
    logic [VA_W-1:0] iova_w;
    logic            st_l1_w, st_l2_w;

    always_ff @(posedge clk) begin
        if (rst)          base_q <= '0;
        else if (base_we) base_q <= base_wdata;
    end

    xw_walk_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .dir_base   (base_q),
        .req_valid  (req_valid),
        .req_iova   (req_iova),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .rsp_valid  (rsp_valid),
        .rsp        (rsp_w),
        .set_l1     (set_l1_w),
        .set_l2     (set_l2_w),
        .cur_iova   (iova_w)
    );

    xw_fault_log u_flt (
        .clk     (clk),
        .rst     (rst),
        .set_l1  (set_l1_w),
        .set_l2  (set_l2_w),
        .iova    (iova_w),
        .clr_l1  (flt_clr_we & flt_clr_data[ST_L1_BIT]),
        .clr_l2  (flt_clr_we & flt_clr_data[ST_L2_BIT]),
        .st_l1   (st_l1_w),
        .st_l2   (st_l2_w),
        .l1_addr (l1_err_addr),
        .l2_addr (l2_err_addr)
    );

    assign rsp_pa         = rsp_w.pa;
    assign rsp_aci        = rsp_w.aci;
    assign rsp_fault      = rsp_w.fault;
    assign rsp_fault_lvl2 = rsp_w.lvl2;

    always_comb begin
        flt_status            = '0;
        flt_status[ST_L1_BIT] = st_l1_w;
        flt_status[ST_L2_BIT] = st_l2_w;
    end

endmodule

// File: tb/xlat_walker_test.sv
module xlat_walker_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] iova;
        logic [31:0] pa;
        logic [3:0]  aci;
        logic [1:0]  kind;   // 0 ok, 1 directory fault, 2 page fault
        logic [2:0]  lat;
        logic [31:0] a1;
        logic [31:0] a2;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h0010_5123, 32'hABCD_E123, 4'h5, 2'd0, 3'd1, 32'h0010_0004, 32'h0020_0414},
        '{32'h123F_F7FF, 32'h1234_57FF, 4'h0, 2'd0, 3'd3, 32'h0010_048C, 32'h0030_03FC},
        '{32'h1230_0ABC, 32'h0000_0000, 4'h0, 2'd2, 3'd2, 32'h0010_048C, 32'h0030_0000},
        '{32'hFFF8_0FFF, 32'hFFFF_FFFF, 4'hA, 2'd0, 3'd4, 32'h0010_3FFC, 32'h0060_0A00},
        '{32'h2000_0000, 32'h0000_0000, 4'h0, 2'd1, 3'd1, 32'h0010_0800, 32'h0},
        '{32'h2010_0010, 32'h0000_0000, 4'h0, 2'd1, 3'd2, 32'h0010_0804, 32'h0},
        '{32'h2020_0000, 32'h0000_0000, 4'h0, 2'd1, 3'd3, 32'h0010_0808, 32'h0},
        '{32'h0010_6000, 32'h0000_1000, 4'hF, 2'd0, 3'd1, 32'h0010_0004, 32'h0020_0418},
        '{32'h7AB0_0000, 32'h0000_0000, 4'h0, 2'd1, 3'd2, 32'h0010_1EAC, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_iova = '0;
    logic        busy;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic [3:0]  rsp_aci;
    logic        rsp_fault;
    logic        rsp_fault_lvl2;
    logic        flt_clr_we = 1'b0;
    logic [17:16] flt_clr_data = '0;
    logic [31:0] flt_status;
    logic [31:0] l1_err_addr;
    logic [31:0] l2_err_addr;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] mem [logic [31:0]];
    int          cur_lat = 1;
    int          log_n = 0;
    logic [31:0] log_a [4];
    bit          pend = 0;
    int          cnt = 0;
    logic [31:0] paddr = '0;

    xlat_walker uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (rst) begin
            pend = 0;
        end else begin
            if (pend) begin
                if (cnt <= 1) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem.exists(paddr) ? mem[paddr] : 32'h0;
                    pend = 0;
                end else begin
                    cnt--;
                end
            end
            if (mem_req) begin
                pend  = 1;
                cnt   = cur_lat;
                paddr = mem_addr;
                if (log_n < 4) log_a[log_n] = mem_addr;
                log_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    logic [31:0] g_pa;
    logic [3:0]  g_aci;
    logic        g_flt, g_l2;

    task automatic walk(input logic [31:0] va, input int lat, input bit hold_other);
        int cyc = 0;
        cur_lat = lat;
        log_n = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_iova  = va;
        @(negedge clk);
        if (hold_other) req_iova = ~va;
        else            req_valid = 1'b0;
        chk(busy == 1'b1, "R7 busy after accept", 32'(busy), 32'h1);
        while (!rsp_valid && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        chk(rsp_valid == 1'b1, "R8 result seen", 32'(rsp_valid), 32'h1);
        chk(busy == 1'b1, "R7 busy in result cycle", 32'(busy), 32'h1);
        g_pa = rsp_pa; g_aci = rsp_aci; g_flt = rsp_fault; g_l2 = rsp_fault_lvl2;
        req_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8 strobe one cycle", 32'(rsp_valid), 32'h0);
        chk(busy == 1'b0, "R7 idle after result", 32'(busy), 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        mem[32'h0010_0004] = 32'h0020_0401;
        mem[32'h0020_0414] = 32'hABCD_E052;
        mem[32'h0020_0418] = 32'h0000_10F2;
        mem[32'h0010_048C] = 32'h0030_0001;
        mem[32'h0030_03FC] = 32'h1234_5F02;
        mem[32'h0030_0000] = 32'h0000_00F0;
        mem[32'h0010_3FFC] = 32'h0060_08FD;
        mem[32'h0060_0A00] = 32'hFFFF_F0A3;
        mem[32'h0010_0800] = 32'h0040_0003;
        mem[32'h0010_0804] = 32'h0050_0000;
        mem[32'h0010_0808] = 32'h0070_0002;
        mem[32'h0080_0004] = 32'h0090_0001;
        mem[32'h0090_0014] = 32'h5555_5032;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && mem_req == 0 && rsp_valid == 0, "R1 idle outputs",
            {29'b0, busy, mem_req, rsp_valid}, 32'h0);
        chk(flt_status == 0, "R1 status", flt_status, 32'h0);
        chk(l1_err_addr == 0 && l2_err_addr == 0, "R1 error addresses",
            l1_err_addr | l2_err_addr, 32'h0);
        rst = 1'b0;
        base_we = 1'b1; base_wdata = 32'h0010_0000;
        @(negedge clk);
        base_we = 1'b0;

        for (int i = 0; i < NV; i++) begin
            walk(VECS[i].iova, int'(VECS[i].lat), 1'b0);
            chk(log_a[0] == VECS[i].a1, "R2 directory read address", log_a[0], VECS[i].a1);
            if (VECS[i].kind == 2'd1) begin
                chk(log_n == 1, "R5 single read on directory fault", 32'(log_n), 32'h1);
                chk(g_flt && !g_l2 && g_pa == 0 && g_aci == 0, "R5 directory fault result",
                    {g_pa[27:0], g_aci[1:0], g_flt, g_l2}, 32'h2);
                chk(l1_err_addr == VECS[i].iova, "R5 l1 error address", l1_err_addr, VECS[i].iova);
                chk(flt_status[16] == 1'b1, "R5 status bit 16", flt_status, 32'h0001_0000);
            end else begin
                chk(log_n == 2, "R3 two reads", 32'(log_n), 32'h2);
                chk(log_a[1] == VECS[i].a2, "R3 page read address", log_a[1], VECS[i].a2);
                if (VECS[i].kind == 2'd2) begin
                    chk(g_flt && g_l2 && g_pa == 0 && g_aci == 0, "R6 page fault result",
                        {g_pa[27:0], g_aci[1:0], g_flt, g_l2}, 32'h3);
                    chk(l2_err_addr == VECS[i].iova, "R6 l2 error address", l2_err_addr, VECS[i].iova);
                    chk(flt_status[17] == 1'b1, "R6 status bit 17", flt_status, 32'h0002_0000);
                end else begin
                    chk(!g_flt && !g_l2, "R4 no fault", {30'b0, g_flt, g_l2}, 32'h0);
                    chk(g_pa == VECS[i].pa, "R4 physical address", g_pa, VECS[i].pa);
                    chk(g_aci == VECS[i].aci, "R4 authority index", 32'(g_aci), 32'(VECS[i].aci));
                end
            end
        end

        // R9: sticky status, selective write-one-to-clear
        chk(flt_status == 32'h0003_0000, "R9 both bits held", flt_status, 32'h0003_0000);
        @(negedge clk);
        flt_clr_we = 1'b1; flt_clr_data = 2'b10;
        @(negedge clk);
        flt_clr_we = 1'b0; flt_clr_data = 2'b11;
        chk(flt_status == 32'h0001_0000, "R9 clear bit 17 only", flt_status, 32'h0001_0000);
        @(negedge clk);
        chk(flt_status == 32'h0001_0000, "R9 clear data ignored without strobe",
            flt_status, 32'h0001_0000);
        flt_clr_we = 1'b1; flt_clr_data = 2'b01;
        @(negedge clk);
        flt_clr_we = 1'b0;
        chk(flt_status == 32'h0, "R9 clear bit 16", flt_status, 32'h0);
        chk(l1_err_addr == 32'h7AB0_0000, "R9 l1 address kept", l1_err_addr, 32'h7AB0_0000);
        chk(l2_err_addr == 32'h1230_0ABC, "R9 l2 address kept", l2_err_addr, 32'h1230_0ABC);

        // R7: a request held high during a walk is ignored
        walk(32'h0010_5123, 3, 1'b1);
        chk(log_n == 2, "R7 no extra reads while busy", 32'(log_n), 32'h2);
        chk(g_pa == 32'hABCD_E123, "R7 first request result kept", g_pa, 32'hABCD_E123);
        repeat (4) @(negedge clk);
        chk(log_n == 2 && !busy, "R7 held request not replayed", 32'(log_n), 32'h2);

        // R2: new base register value steers later walks
        base_we = 1'b1; base_wdata = 32'h0080_0000;
        @(negedge clk);
        base_we = 1'b0;
        walk(32'h0010_5123, 2, 1'b0);
        chk(log_a[0] == 32'h0080_0004, "R2 new base used", log_a[0], 32'h0080_0004);
        chk(g_pa == 32'h5555_5123 && g_aci == 4'h3, "R4 result under new base",
            g_pa, 32'h5555_5123);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule